// File: doc/BRIEF.md
# Line Pixel Counter with Buffered Divisor

This block is the digital feedback divider of a line-locked pixel clock generator. It counts pixel clocks across a video line and emits a one-cycle line-start pulse at the beginning of every line, along with a regenerated horizontal sync pulse of programmable width. The line length comes from a 12-bit divisor. A line lasts the divisor plus one pixel clocks.

Software loads the divisor through a byte-wide register write port in two parts: an upper byte and a lower nibble. Writing the upper byte only updates a shadow copy. Writing the lower-nibble register assembles the full 12-bit value and queues it. The queued value becomes active at the next line boundary, so the line in progress always finishes at its old length. Divisor values below two are raised to two. A third register sets the sync pulse width in pixel clocks, and that width also takes effect at the next line start. Reads return the shadow bytes as they were written.

Top module: `pixel_line_divider`

## Requirements
- R1: After reset the active divisor is 1693, so the first lines last 1694 cycles. The upper shadow (address 0x01) reads 0x69, the lower register (address 0x02) reads 0xD0, and the width register (address 0x07) reads 0x20.
- R2: `lineStart` is high for exactly one cycle per line, and consecutive rises are active-divisor-plus-one cycles apart, up to a divisor of 4095.
- R3: A write to address 0x01 alone leaves the line length unchanged.
- R4: A write to address 0x02 forms the divisor from the upper shadow byte (bits 11:4) and write-data bits 7:4 (bits 3:0). The line in progress completes at its old length, and the new divisor governs the line that starts next.
- R5: An assembled divisor below 2 is stored as 2, which gives 3-cycle lines.
- R6: `hsyncOut` rises in the same cycle as `lineStart` and stays high for the width held in address 0x07. A new width applies from the next line start.
- R7: A width of 0 keeps `hsyncOut` low for the whole line.
- R8: A width of at least the line length keeps `hsyncOut` high for the whole line.
- R9: `regRdData` returns the written upper byte at 0x01, the written nibble in bits 7:4 with bits 3:0 zero at 0x02, and the width at 0x07, all before any clamping. It returns zero at every other address.
- R10: Writes to any other address change neither the readable registers nor the line timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register address for write and read |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Shadow register read data for `regAddr` |
| lineStart | output | 1 | One-cycle pulse at the first pixel of each line |
| hsyncOut | output | 1 | Regenerated horizontal sync pulse |

## Verification
The bench builds the block with its default parameters: a 1693 reset divisor, a 32-cycle reset width and a floor of 2. This lets it observe the full-length reset line, the clamp at the floor and the 4095 maximum, all within one run. Small divisors written at run time produce 3-cycle and 10-cycle lines. On these lines the 32-cycle width exceeds the line length, and widths of 0 and 3 can be compared against a complete line in a few cycles.

// File: rtl/pixel_line_divider_pkg.sv
package pixel_line_divider_pkg;
  localparam int DIV_W  = 12;
  localparam int HI_W   = 8;
  localparam int LO_W   = DIV_W - HI_W;
  localparam int HSW_W  = 8;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;

  // Strobes and values handed from register control to the counting datapath
  typedef struct packed {
    logic             applyDiv;
    logic [DIV_W-1:0] newDiv;
    logic [HSW_W-1:0] width;
  } lineCtl_t;
endpackage

// File: rtl/pixel_line_divider_regs.sv
module pixel_line_divider_regs
  import pixel_line_divider_pkg::*;
#(
  parameter int ADDR_DIV_HI   = 1,
  parameter int ADDR_DIV_LO   = 2,
  parameter int ADDR_HS_WIDTH = 7,
  parameter int RESET_DIV     = 1693,
  parameter int RESET_WIDTH   = 32,
  parameter int MIN_DIV       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              lineEnd,
  output lineCtl_t          ctl,
  output logic [DATA_W-1:0] rdData
);
  localparam logic [DIV_W-1:0]  RST_DIV_V = DIV_W'(RESET_DIV);
  localparam logic [DIV_W-1:0]  MIN_V     = DIV_W'(MIN_DIV);
  localparam logic [HSW_W-1:0]  RST_W_V   = HSW_W'(RESET_WIDTH);
  localparam logic [ADDR_W-1:0] A_HI      = ADDR_W'(ADDR_DIV_HI);
  localparam logic [ADDR_W-1:0] A_LO      = ADDR_W'(ADDR_DIV_LO);
  localparam logic [ADDR_W-1:0] A_HSW     = ADDR_W'(ADDR_HS_WIDTH);

  logic [HI_W-1:0]  shadowHi;
  logic [LO_W-1:0]  shadowLo;
  logic [HSW_W-1:0] widthReg;
  logic [DIV_W-1:0] pendingDiv;
  logic             pendingValid;

  logic             wrHi, wrLo, wrHsw;
  logic [DIV_W-1:0] assembled, clamped;

  assign wrHi      = wrEn && (addr == A_HI);
  assign wrLo      = wrEn && (addr == A_LO);
  assign wrHsw     = wrEn && (addr == A_HSW);
  assign assembled = {shadowHi, wrData[DATA_W-1 -: LO_W]};
  assign clamped   = (assembled < MIN_V) ? MIN_V : assembled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadowHi     <= RST_DIV_V[DIV_W-1 -: HI_W];
      shadowLo     <= RST_DIV_V[LO_W-1:0];
      widthReg     <= RST_W_V;
      pendingDiv   <= RST_DIV_V;
      pendingValid <= 1'b0;
    end else begin
      if (wrHi) shadowHi <= wrData;
      if (wrHsw) widthReg <= wrData[HSW_W-1:0];
      if (wrLo) begin
        shadowLo   <= wrData[DATA_W-1 -: LO_W];
        pendingDiv <= clamped;
      end
      // a fresh low write wins over the handoff at a line boundary
      if (wrLo) pendingValid <= 1'b1;
      else if (lineEnd) pendingValid <= 1'b0;
    end
  end

  assign ctl.applyDiv = pendingValid && lineEnd;
  assign ctl.newDiv   = pendingDiv;
  assign ctl.width    = widthReg;

  always_comb begin
    rdData = '0;
    if (addr == A_HI) rdData = shadowHi;
    else if (addr == A_LO) rdData = {shadowLo, {(DATA_W-LO_W){1'b0}}};
    else if (addr == A_HSW) rdData = DATA_W'(widthReg);
  end
endmodule

// File: rtl/pixel_line_divider_datapath.sv
module pixel_line_divider_datapath
  import pixel_line_divider_pkg::*;
#(
  parameter int RESET_DIV   = 1693,
  parameter int RESET_WIDTH = 32
) (
  input  logic     clk,
  input  logic     rst_n,
  input  lineCtl_t ctl,
  output logic     lineEnd,
  output logic     lineStart,
  output logic     hsyncOut
);
  localparam logic [DIV_W-1:0] RST_DIV_V = DIV_W'(RESET_DIV);
  localparam logic [HSW_W-1:0] RST_W_V   = HSW_W'(RESET_WIDTH);

  logic [DIV_W-1:0] pixCnt;
  logic [DIV_W-1:0] activeDiv;
  logic [HSW_W-1:0] lineWidth;

  assign lineEnd   = (pixCnt == activeDiv);
  assign lineStart = (pixCnt == '0);
  assign hsyncOut  = (pixCnt < DIV_W'(lineWidth));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pixCnt    <= '0;
      activeDiv <= RST_DIV_V;
      lineWidth <= RST_W_V;
    end else if (lineEnd) begin
      pixCnt    <= '0;
      lineWidth <= ctl.width;
      if (ctl.applyDiv) activeDiv <= ctl.newDiv;
    end else begin
      pixCnt <= pixCnt + 1'b1;
    end
  end
endmodule

// File: rtl/pixel_line_divider.sv
module pixel_line_divider
  import pixel_line_divider_pkg::*;
#(
  parameter int ADDR_DIV_HI   = 1,
  parameter int ADDR_DIV_LO   = 2,
  parameter int ADDR_HS_WIDTH = 7,
  parameter int RESET_DIV     = 1693,
  parameter int RESET_WIDTH   = 32,
  parameter int MIN_DIV       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              lineStart,
  output logic              hsyncOut
);
  lineCtl_t ctl;
  logic     lineEnd;

  pixel_line_divider_regs #(
    .ADDR_DIV_HI(ADDR_DIV_HI), .ADDR_DIV_LO(ADDR_DIV_LO),
    .ADDR_HS_WIDTH(ADDR_HS_WIDTH), .RESET_DIV(RESET_DIV),
    .RESET_WIDTH(RESET_WIDTH), .MIN_DIV(MIN_DIV)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wrEn(regWrEn), .addr(regAddr),
    .wrData(regWrData), .lineEnd(lineEnd), .ctl(ctl), .rdData(regRdData)
  );

  pixel_line_divider_datapath #(
    .RESET_DIV(RESET_DIV), .RESET_WIDTH(RESET_WIDTH)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .lineEnd(lineEnd),
    .lineStart(lineStart), .hsyncOut(hsyncOut)
  );
endmodule

// File: rtl/pixel_line_divider_checks.sv
module pixel_line_divider_checks
  import pixel_line_divider_pkg::*;
#(
  parameter int MIN_DIV = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lineStart,
  input logic             hsyncOut,
  input logic [DIV_W-1:0] pixCnt,
  input logic [DIV_W-1:0] activeDiv,
  input logic [HSW_W-1:0] lineWidth
);
  a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    lineStart |=> !lineStart);

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pixCnt <= activeDiv);

  a_r4_div_only_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    !lineStart |-> $stable(activeDiv));

  a_r5_div_floor: assert property (@(posedge clk) disable iff (!rst_n)
    activeDiv >= DIV_W'(MIN_DIV));

  a_r6_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsyncOut) |-> lineStart);

  a_r7_zero_width_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (lineWidth == '0) |-> !hsyncOut);

  a_r8_long_width_full: assert property (@(posedge clk) disable iff (!rst_n)
    (DIV_W'(lineWidth) > activeDiv) |-> hsyncOut);
endmodule

bind pixel_line_divider pixel_line_divider_checks #(.MIN_DIV(MIN_DIV)) u_checks (
  .clk(clk), .rst_n(rst_n), .lineStart(lineStart), .hsyncOut(hsyncOut),
  .pixCnt(u_dp.pixCnt), .activeDiv(u_dp.activeDiv), .lineWidth(u_dp.lineWidth)
);

// File: tb/pixel_line_divider_bench.sv
`timescale 1ns/1ps
module pixel_line_divider_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regAddr = 8'h00;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       lineStart, hsyncOut;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  pixel_line_divider u_pixel_line_divider (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .lineStart(lineStart), .hsyncOut(hsyncOut)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int mCnt = 0, mActive = 1693, mPend = 1693, mHi = 'h69, mLo = 'hD;
  int mWidthReg = 32, mWidthLine = 32;
  bit mPendValid = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mCnt = 0; mActive = 1693; mPend = 1693; mPendValid = 0;
      mHi = 'h69; mLo = 'hD; mWidthReg = 32; mWidthLine = 32;
    end else begin
      int oldWidth;
      oldWidth = mWidthReg;
      if (mCnt == mActive) begin
        mCnt = 0;
        if (mPendValid) mActive = mPend;
        mPendValid = 0;
        mWidthLine = oldWidth;
      end else mCnt++;
      if (regWrEn) begin
        if (regAddr == 8'h01) mHi = regWrData;
        else if (regAddr == 8'h02) begin
          int v;
          mLo = regWrData >> 4;
          v = mHi * 16 + mLo;
          mPend = (v < 2) ? 2 : v;
          mPendValid = 1;
        end else if (regAddr == 8'h07) mWidthReg = regWrData;
      end
    end
  end

  function automatic int modelRead(input int a);
    if (a == 1) return mHi;
    if (a == 2) return mLo * 16;
    if (a == 7) return mWidthReg;
    return 0;
  endfunction

  // Per-cycle comparison and line observation
  int lineCount = 0, curLen = 0, curHs = 0, lastPeriod = 0, lastHs = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      check(lineStart == (mCnt == 0), "R2 lineStart vs model", lineStart, mCnt == 0);
      check(hsyncOut == (mCnt < mWidthLine), "R6 hsyncOut vs model", hsyncOut, mCnt < mWidthLine);
      check(int'(regRdData) == modelRead(regAddr), "R9 read data vs model",
            regRdData, modelRead(regAddr));
      if (lineStart) begin
        if (curLen > 0) begin
          lastPeriod = curLen; lastHs = curHs; lineCount++;
        end
        curLen = 1; curHs = hsyncOut;
      end else begin
        curLen++; curHs += hsyncOut;
      end
    end
  end

  task automatic writeReg(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0; regAddr = 8'h00;
  endtask

  task automatic readReg(input logic [7:0] a, input int exp, input string req);
    @(posedge clk); #1;
    regAddr = a;
    @(negedge clk);
    check(int'(regRdData) == exp, req, regRdData, exp);
  endtask

  task automatic waitLines(input int n);
    int target;
    target = lineCount + n;
    while (lineCount < target) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state
    readReg(8'h01, 'h69, "R1 reset upper byte");
    readReg(8'h02, 'hD0, "R1 reset lower register");
    readReg(8'h07, 'h20, "R1 reset width");
    waitLines(2);
    check(lastPeriod == 1694, "R1 reset line length", lastPeriod, 1694);
    check(lastHs == 32, "R6 reset width pulse", lastHs, 32);
    // R3: upper byte alone
    writeReg(8'h01, 8'h00);
    waitLines(2);
    check(lastPeriod == 1694, "R3 upper write alone", lastPeriod, 1694);
    // R4: low write, deferred to next line
    writeReg(8'h02, 8'h90);
    waitLines(1);
    check(lastPeriod == 1694, "R4 current line keeps old length", lastPeriod, 1694);
    waitLines(1);
    check(lastPeriod == 10, "R4 new divisor applied", lastPeriod, 10);
    check(lastHs == 10, "R8 width beyond line length", lastHs, 10);
    // R6: width change
    writeReg(8'h07, 8'h03);
    waitLines(2);
    check(lastHs == 3, "R6 width 3 pulse", lastHs, 3);
    // R7: width zero
    writeReg(8'h07, 8'h00);
    waitLines(2);
    check(lastHs == 0, "R7 zero width", lastHs, 0);
    // R5: clamp to floor
    writeReg(8'h02, 8'h00);
    waitLines(2);
    check(lastPeriod == 3, "R5 clamped divisor", lastPeriod, 3);
    readReg(8'h02, 'h00, "R9 shadow reads unclamped");
    // R10: unmapped writes
    writeReg(8'h03, 8'hFF);
    writeReg(8'h00, 8'hFF);
    readReg(8'h01, 'h00, "R10 upper untouched");
    readReg(8'h02, 'h00, "R10 lower untouched");
    readReg(8'h07, 'h00, "R10 width untouched");
    readReg(8'h05, 'h00, "R9 unmapped reads zero");
    waitLines(2);
    check(lastPeriod == 3, "R10 timing untouched", lastPeriod, 3);
    // R2: maximum divisor
    writeReg(8'h07, 8'h05);
    writeReg(8'h01, 8'hFF);
    writeReg(8'h02, 8'hF0);
    waitLines(3);
    check(lastPeriod == 4096, "R2 maximum line length", lastPeriod, 4096);
    check(lastHs == 5, "R6 width 5 pulse", lastHs, 5);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule